// File: doc/BRIEF.md
# Gated UART Receive Holding Buffer

This block is the byte store that sits between a UART's serial receiver and the software-visible data register. Received bytes enter through a valid/ready stream and are kept in a small circular store, tracked by a head index and an occupancy count. The receiver is told how much room is left. When reception is halted, the block reports no room and accepts nothing.

Software pops a byte by reading the data register. The byte at the head is always on `head_byte`. The head advances only when reception is running and the store holds something. A receive-ready event flag follows the contents. Storing a byte sets it. A pop that leaves bytes behind sets it again. Software lowers it only by writing zero to the event register.

Reception is controlled by a two-state machine. HALTED moves to ACTIVE on the START transition (`run_set` without `run_clr`). ACTIVE moves to HALTED on the STOP transition (`run_clr`, which wins over `run_set`). The event flag is a second two-state machine. EV_IDLE moves to EV_RAISED on RAISE (any set cause). EV_RAISED moves to EV_IDLE on LOWER (a zero written to the event register with no set cause in the same cycle).

Top module: `uart_rxbuf`

## Requirements
- R1: `in_ready` is high exactly when reception is ACTIVE and the occupancy is below DEPTH. `free_space` equals DEPTH minus the occupancy while ACTIVE, and 0 while HALTED.
- R2: An accepted byte (`in_valid` and `in_ready` high at a clock edge) is written at slot (head + occupancy) modulo DEPTH, and the occupancy rises by one. Bytes leave in arrival order, including across the wrap of the store.
- R3: The occupancy never exceeds DEPTH. While it equals DEPTH, input is refused and `in_valid` has no effect.
- R4: The cycle after a byte is accepted, `rx_ready` is 1.
- R5: A `rd_strobe` cycle while ACTIVE with occupancy above zero advances the head modulo DEPTH and lowers the occupancy by one. `head_byte` always shows the byte at the head slot.
- R6: A `rd_strobe` cycle while HALTED, or while the store is empty, changes neither the occupancy nor `head_byte`.
- R7: A pop that leaves at least one byte sets `rx_ready` again. A pop that empties the store does not set it.
- R8: A register write with `reg_sel`=1 (event register) and `reg_wdata`=0 lowers `rx_ready`. A nonzero value leaves it unchanged. A set cause in the same cycle wins over the lowering.
- R9: A register write with `reg_sel`=0 (data register) has no effect on any output.
- R10: After reset the occupancy is 0, the head is 0, reception is HALTED, `rx_ready` is 0 and `head_byte` is 0.
- R11: `run_set` enters ACTIVE and `run_clr` enters HALTED. When both are high, the block ends HALTED. Halting keeps the stored bytes.
- R12: An accept and a pop in the same cycle leave the occupancy unchanged, advance the head, and store the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_set | input | 1 | Start-reception strobe |
| run_clr | input | 1 | Stop-reception strobe |
| in_data | input | 8 | Byte from the serial receiver |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Buffer accepts a byte this cycle |
| free_space | output | CW | Free slots offered to the receiver |
| rd_strobe | input | 1 | Data-register read (pop request) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 data register, 1 event register |
| reg_wdata | input | 8 | Register write value |
| head_byte | output | 8 | Byte at the head slot |
| occupancy | output | CW | Number of stored bytes |
| rx_ready | output | 1 | Receive-ready event flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a receiver accept and a software pop. The bench provokes it by holding `in_valid` and `rd_strobe` high together on a non-empty store. It then judges that the occupancy is unchanged and that the next byte is at the head. The second pair is an event set and an event lowering. The bench provokes it by writing zero to the event register in the same cycle as an accept. It then judges that `rx_ready` stays high.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic {
        RUN_HALTED = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef enum logic {
        EV_IDLE   = 1'b0,
        EV_RAISED = 1'b1
    } evt_state_e;

    localparam logic SEL_DATA  = 1'b0;
    localparam logic SEL_EVENT = 1'b1;
endpackage

// File: rtl/rxbuf_run_ctrl.sv
module rxbuf_run_ctrl
    import uart_rxbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_set,
    input  logic run_clr,
    output logic running
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED: if (run_set && !run_clr) state_d = RUN_ACTIVE;  // START
            RUN_ACTIVE: if (run_clr)             state_d = RUN_HALTED;  // STOP
            default:                             state_d = RUN_HALTED;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_ACTIVE);
    end
endmodule

// File: rtl/rxbuf_event.sv
module rxbuf_event
    import uart_rxbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic evt
);
    evt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:   if (set_evt)             state_d = EV_RAISED; // RAISE
            EV_RAISED: if (clr_evt && !set_evt) state_d = EV_IDLE;   // LOWER
            default:                            state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        evt = (state_q == EV_RAISED);
    end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  byte_t         push_byte,
    output byte_t         head_byte,
    output logic [CW-1:0] count
);
    localparam logic [CW:0]   DEPTH_X = (CW + 1)'(DEPTH);
    localparam logic [PW-1:0] LAST_IX = PW'(DEPTH - 1);

    byte_t         mem [DEPTH];
    logic [PW-1:0] head_q;
    logic [CW-1:0] count_q;
    logic [CW:0]   wr_sum;
    logic [PW-1:0] wr_ix;
    logic [PW-1:0] head_nx;

    always_comb begin
        wr_sum  = (CW + 1)'(head_q) + (CW + 1)'(count_q);
        wr_ix   = (wr_sum >= DEPTH_X) ? PW'(wr_sum - DEPTH_X) : PW'(wr_sum);
        head_nx = (head_q == LAST_IX) ? '0 : head_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) mem[wr_ix] <= push_byte;
            if (pop)  head_q <= head_nx;
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_byte = mem[head_q];
    assign count     = count_q;
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_set,
    input  logic          run_clr,
    input  logic [7:0]    in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [CW-1:0] free_space,
    input  logic          rd_strobe,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    head_byte,
    output logic [CW-1:0] occupancy,
    output logic          rx_ready
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic running;
    logic push, pop, remain, set_evt, clr_evt;

    rxbuf_run_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_set (run_set),
        .run_clr (run_clr),
        .running (running)
    );

    rxbuf_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_byte (in_data),
        .head_byte (head_byte),
        .count     (occupancy)
    );

    rxbuf_event u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_evt (clr_evt),
        .evt     (rx_ready)
    );

    always_comb begin
        in_ready   = running && (occupancy != DEPTH_C);
        free_space = running ? (DEPTH_C - occupancy) : '0;
        push       = in_valid && in_ready;
        pop        = rd_strobe && running && (occupancy != '0);
        remain     = push || (occupancy > CW'(1));
        set_evt    = push || (pop && remain);
        // data-register writes (reg_sel == SEL_DATA) are decoded to nothing
        clr_evt    = reg_wr && (reg_sel == SEL_EVENT) && (reg_wdata == 8'h00);
    end
endmodule

// File: rtl/uart_rxbuf_chk.sv
module uart_rxbuf_chk #(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          running,
    input logic          in_valid,
    input logic          in_ready,
    input logic [CW-1:0] free_space,
    input logic          rd_strobe,
    input logic          reg_wr,
    input logic          reg_sel,
    input logic [7:0]    reg_wdata,
    input logic [CW-1:0] occupancy,
    input logic          rx_ready
);
    localparam logic [CW-1:0] DC = CW'(DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= DC);

    assert_refuse_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == DC) |-> !in_ready);

    assert_halted_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (free_space == '0 && !in_ready));

    assert_push_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> rx_ready);

    assert_pop_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && running && occupancy != '0 && !(in_valid && in_ready))
        |=> (occupancy == $past(occupancy) - 1'b1));

    assert_idle_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (!running || occupancy == '0) && !(in_valid && in_ready))
        |=> $stable(occupancy));

    assert_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata == 8'h00 && !(in_valid && in_ready)
         && !(rd_strobe && running && occupancy > CW'(1)))
        |=> !rx_ready);

    assert_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && rd_strobe && occupancy != '0)
        |=> $stable(occupancy));
endmodule

bind uart_rxbuf uart_rxbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .free_space (free_space),
    .rd_strobe  (rd_strobe),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .occupancy  (occupancy),
    .rx_ready   (rx_ready)
);

// File: tb/sim_uart_rxbuf.sv
`timescale 1ns/1ps
module sim_uart_rxbuf;
    localparam int DEPTH = 6;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_set = 1'b0, run_clr = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [CW-1:0] free_space;
    logic          rd_strobe = 1'b0;
    logic          reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    head_byte;
    logic [CW-1:0] occupancy;
    logic          rx_ready;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_rxbuf #(.DEPTH(DEPTH)) u0 (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        run_set = 0; run_clr = 0; in_valid = 0; rd_strobe = 0; reg_wr = 0;
    endtask

    task automatic push(input logic [7:0] b);
        in_valid = 1; in_data = b;
        cyc();
    endtask

    task automatic ev_write(input logic [7:0] v);
        reg_wr = 1; reg_sel = 1; reg_wdata = v;
        cyc();
    endtask

    task automatic t_reset();
        chk("R10", "occupancy", occupancy, 0);
        chk("R10", "rx_ready", rx_ready, 0);
        chk("R10", "head_byte", head_byte, 0);
        chk("R10", "free_space", free_space, 0);
        chk("R10", "in_ready", in_ready, 0);
    endtask

    task automatic t_halted_refuse();
        push(8'h77);
        chk("R1", "halted occupancy", occupancy, 0);
        chk("R1", "halted rx_ready", rx_ready, 0);
    endtask

    task automatic t_start();
        run_set = 1; cyc();
        chk("R11", "in_ready after start", in_ready, 1);
        chk("R1", "free after start", free_space, DEPTH);
    endtask

    task automatic t_fill();
        push(8'hA1);
        chk("R4", "rx_ready after push", rx_ready, 1);
        chk("R2", "occupancy 1", occupancy, 1);
        for (int i = 2; i <= DEPTH; i++) push(8'hA0 + 8'(i));
        chk("R3", "occupancy full", occupancy, DEPTH);
        chk("R1", "free full", free_space, 0);
        chk("R3", "in_ready full", in_ready, 0);
        push(8'hEE);
        chk("R3", "no overflow", occupancy, DEPTH);
        chk("R5", "head first", head_byte, 8'hA1);
    endtask

    task automatic t_clear();
        ev_write(8'h01);
        chk("R8", "nonzero keeps", rx_ready, 1);
        ev_write(8'h00);
        chk("R8", "zero lowers", rx_ready, 0);
    endtask

    task automatic t_data_write();
        reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00; cyc();
        chk("R9", "occupancy", occupancy, DEPTH);
        chk("R9", "head_byte", head_byte, 8'hA1);
        chk("R9", "rx_ready", rx_ready, 0);
        chk("R9", "free_space", free_space, 0);
    endtask

    task automatic t_drain();
        for (int i = 1; i <= DEPTH; i++) begin
            chk("R5", "order", head_byte, 8'hA0 + 8'(i));
            rd_strobe = 1; cyc();
            chk("R5", "count down", occupancy, DEPTH - i);
            chk("R7", "re-raise", rx_ready, (i < DEPTH) ? 1 : 0);
            ev_write(8'h00);
        end
    endtask

    task automatic t_empty_read();
        logic [7:0] h;
        h = head_byte;
        rd_strobe = 1; cyc();
        chk("R6", "empty occupancy", occupancy, 0);
        chk("R6", "empty head", head_byte, h);
        chk("R7", "empty no raise", rx_ready, 0);
    endtask

    task automatic t_wrap();
        push(8'hB1); push(8'hB2); push(8'hB3);
        rd_strobe = 1; cyc();
        rd_strobe = 1; cyc();
        chk("R5", "head after two pops", head_byte, 8'hB3);
        for (int i = 1; i <= 5; i++) push(8'hC0 + 8'(i));
        chk("R2", "wrap occupancy", occupancy, DEPTH);
        chk("R2", "wrap head", head_byte, 8'hB3);
        rd_strobe = 1; cyc();
        for (int i = 1; i <= 5; i++) begin
            chk("R2", "wrap order", head_byte, 8'hC0 + 8'(i));
            rd_strobe = 1; cyc();
        end
        chk("R2", "wrap drained", occupancy, 0);
    endtask

    task automatic t_both();
        push(8'hD1);
        in_valid = 1; in_data = 8'hD2; rd_strobe = 1; cyc();
        chk("R12", "occupancy kept", occupancy, 1);
        chk("R12", "head advanced", head_byte, 8'hD2);
        rd_strobe = 1; cyc();
        chk("R5", "pop last", occupancy, 0);
    endtask

    task automatic t_set_beats_clear();
        ev_write(8'h00);
        in_valid = 1; in_data = 8'hE1; reg_wr = 1; reg_sel = 1; reg_wdata = 8'h00; cyc();
        chk("R8", "set wins", rx_ready, 1);
        chk("R2", "occupancy", occupancy, 1);
    endtask

    task automatic t_halt();
        run_clr = 1; cyc();
        chk("R11", "halt keeps bytes", occupancy, 1);
        chk("R1", "halted free", free_space, 0);
        rd_strobe = 1; cyc();
        chk("R6", "halted read occupancy", occupancy, 1);
        chk("R6", "halted read head", head_byte, 8'hE1);
        run_set = 1; run_clr = 1; cyc();
        chk("R11", "both strobes halt", in_ready, 0);
        run_set = 1; cyc();
        chk("R11", "restart free", free_space, DEPTH - 1);
    endtask

    task automatic t_reset2();
        rst_n = 0; cyc(); rst_n = 1;
        chk("R10", "reset occupancy", occupancy, 0);
        chk("R10", "reset halted", free_space, 0);
        chk("R10", "reset rx_ready", rx_ready, 0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_halted_refuse();
        t_start();
        t_fill();
        t_clear();
        t_data_write();
        t_drain();
        t_empty_read();
        t_wrap();
        t_both();
        t_set_beats_clear();
        t_halt();
        t_reset2();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule